// File: doc/BRIEF.md
# Smart Card Character Transmitter

This block sends bytes one character at a time over the single data line of an asynchronous, half-duplex smart card link. Each character goes out as a low start bit, the eight data bits least significant first, an even parity bit, and then a reserved interval during which the card may pull the line low to report an error. A baud-rate generator outside the block supplies `bit_tick`, a one-cycle pulse per bit period. The block does not watch the line during the reserved interval; receive and retransmission belong to other logic.

Software writes bytes into a one-byte holding register through a small register port. A shift register behind it sends the frames. An empty flag says when the holding register can take the next byte, so back-to-back characters go out with no idle gap. A transmit-end flag is set at the end of every character, including each boundary in a back-to-back run. The interrupt output is that flag ANDed with a separate enable. Software normally sets the enable only once the final byte has moved into the shift register, so that only the last frame raises the interrupt.

Top module: `sc_char_tx`

## Requirements
- R1: After reset the line is high, irq is low, the control register reads 0x00 and the status register reads 0x01 (empty = 1, transmit-end = 0).
- R2: The line carries a start bit (0) and then data bits D0..D7 in order. Each bit lasts one bit period, and the line changes only at a clock edge where `bit_tick` is high. The start bit appears on the clock edge that loads the shift register.
- R3: The bit after D7 is even parity: it equals the XOR of D0..D7.
- R4: After parity the line stays high for GUARD_BITS bit periods (default 2), and the transmit-end flag stays 0 during that time. The frame ends on the following tick, so a frame spans 10 + GUARD_BITS ticks.
- R5: A write to address 1 stores the byte and clears empty (status bit 0). The byte is loaded on the next clock edge when transmission is enabled (control bit 0), the shifter is idle and the holding register is full. The load sets empty again and clears transmit-end.
- R6: At the end of every frame, transmit-end (status bit 1) is set to 1. If the holding register is full at that edge, the next frame's start bit begins on the same edge and empty returns to 1, with transmit-end still set.
- R7: irq is high exactly when transmit-end and the interrupt enable (control bit 1) are both 1. Changing the enable does not alter the transmit-end flag.
- R8: Writing status (address 2) with bit 1 = 1 clears transmit-end. Writing it with bit 1 = 0 leaves transmit-end unchanged.
- R9: Clearing transmit enable forces the line high and abandons the current frame. The holding register keeps its byte, and no frame starts while transmission is disabled.
- R10: Reads return control {6'b0, irq_enable, tx_enable} at address 0, the holding byte at address 1 and {6'b0, transmit-end, empty} at address 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address (0 control, 1 data, 2 status) |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr`, combinational |
| line_out | output | 1 | Serial data line to the card, idles high |
| irq | output | 1 | Transmit-end interrupt request |

## Verification
A register write takes effect at the edge where `wr_en` is sampled, so the flags and readback are checked at the next falling edge. A load from idle happens one edge later, and the start bit and restored empty flag are checked at the falling edge after that. Each line change and the end of a frame fall on the edge where `bit_tick` is high. The bench raises `bit_tick` for exactly one rising edge at a time and samples at the falling edge that follows. Disabling needs two edges: one to write control and one for the shifter to drop the frame. The line is checked after both.

// File: rtl/sc_tx_pkg.sv
// Package: shared constants, register addresses and the parity helper
// for the smart card character transmitter.
package sc_tx_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL = 2'd0,
        REG_DATA = 2'd1,
        REG_STAT = 2'd2
    } sc_reg_e;

    // Even parity bit: makes the count of ones over data plus parity even.
    function automatic logic even_parity(input logic [DATA_W-1:0] d);
        return ^d;
    endfunction
endpackage

// File: rtl/sc_tx_regs.sv
// sc_tx_regs: host register file. It holds the control bits, the one-byte
// holding register, the empty and transmit-end flags, and the interrupt gate.
// Assumes load and frame_end come from the shifter and the top-level load
// decision, and that a data write and a load in the same cycle are legal
// (the load takes the old byte and the new byte stays).
module sc_tx_regs
    import sc_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load,
    input  logic              frame_end,
    output logic              tx_en,
    output logic              irq_en,
    output logic [DATA_W-1:0] hold_data,
    output logic              hold_full,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    logic wr_ctrl, wr_data_q, wr_stat;

    // Decode which register a write targets.
    always_comb begin
        wr_ctrl   = wr_en && (addr == REG_CTRL);
        wr_data_q = wr_en && (addr == REG_DATA);
        wr_stat   = wr_en && (addr == REG_STAT);
    end

    // Control bits: transmit enable and interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en  <= 1'b0;
            irq_en <= 1'b0;
        end else if (wr_ctrl) begin
            tx_en  <= wr_data[0];
            irq_en <= wr_data[1];
        end
    end

    // Holding register byte.
    always_ff @(posedge clk) begin
        if (!rst_n)         hold_data <= '0;
        else if (wr_data_q) hold_data <= wr_data;
    end

    // Full flag: a write fills the register, a load empties it, and the write wins.
    always_ff @(posedge clk) begin
        if (!rst_n)         hold_full <= 1'b0;
        else if (wr_data_q) hold_full <= 1'b1;
        else if (load)      hold_full <= 1'b0;
    end

    // Transmit-end flag: set at each frame end (highest priority), cleared by a load or a write-1-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                     done <= 1'b0;
        else if (frame_end)             done <= 1'b1;
        else if (load)                  done <= 1'b0;
        else if (wr_stat && wr_data[1]) done <= 1'b0;
    end

    // Read multiplexer.
    always_comb begin
        case (addr)
            REG_CTRL: rd_data = {{(DATA_W-2){1'b0}}, irq_en, tx_en};
            REG_DATA: rd_data = hold_data;
            REG_STAT: rd_data = {{(DATA_W-2){1'b0}}, done, ~hold_full};
            default:  rd_data = '0;
        endcase
    end

    // Interrupt request gated by the enable.
    assign irq = done & irq_en;

    // R6: every frame end leaves the flag set.
    a_r6_end_sets_done: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> done);
    // R5: a load with no write in the same cycle leaves the holding register empty.
    a_r5_load_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !wr_data_q) |=> !hold_full);
    // R5: a data write always fills the holding register.
    a_r5_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data_q |=> hold_full);
    // R8: a status write with bit 1 clear does not drop the flag.
    a_r8_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && !wr_data[1] && done && !load) |=> done);
endmodule

// File: rtl/sc_tx_shifter.sv
// sc_tx_shifter: frame sequencer. On load it builds start, data, parity and
// guard, then shifts one bit per bit_tick. It reports frame_end on the tick
// that closes the last guard period. Assumes bit_tick is a one-cycle pulse
// and that load is only raised while enable is high.
module sc_tx_shifter
    import sc_tx_pkg::*;
#(
    parameter int GUARD_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              bit_tick,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              busy,
    output logic              line,
    output logic              frame_end
);
    localparam int SH_W   = DATA_W + 2;            // start + data + parity
    localparam int FRAME  = SH_W + GUARD_BITS;     // bit periods per frame
    localparam int CNT_W  = $clog2(FRAME + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME - 1);

    logic [SH_W-1:0]  sh;
    logic [CNT_W-1:0] cnt;

    // Frame end strobe: last bit period of a live frame is closed by a tick.
    assign frame_end = enable && busy && bit_tick && (cnt == LAST);

    // Busy, shift register and bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            busy <= 1'b0;
            sh   <= '1;
            cnt  <= '0;
        end else if (load) begin
            busy <= 1'b1;
            sh   <= {even_parity(load_data), load_data, 1'b0};
            cnt  <= '0;
        end else if (busy && bit_tick) begin
            if (cnt == LAST) begin
                busy <= 1'b0;
                sh   <= '1;
                cnt  <= '0;
            end else begin
                sh   <= {1'b1, sh[SH_W-1:1]};
                cnt  <= cnt + 1'b1;
            end
        end
    end

    // Line: current shift bit while busy, otherwise idle high.
    assign line = busy ? sh[0] : 1'b1;

    // R9: once disabled, the line is high and the shifter idle.
    a_r9_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (line && !busy));
    // R2: a load drives the start bit on the next cycle.
    a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        (load && enable) |=> !line);
    // R4: guard periods keep the line high.
    a_r4_guard_high: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt >= CNT_W'(SH_W)) |-> line);
    // R2: without a tick or load, the line holds its value.
    a_r2_no_tick_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !bit_tick && !load) |=> $stable(line));
endmodule

// File: rtl/sc_char_tx.sv
// sc_char_tx: top level of the smart card character transmitter. Joins the
// register file and the frame shifter and decides when the holding byte
// moves into the shift register. Assumes bit_tick comes from an outside
// baud generator at one pulse per bit period.
module sc_char_tx
    import sc_tx_pkg::*;
#(
    parameter int GUARD_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    output logic              line_out,
    output logic              irq
);
    logic              tx_en, irq_en, hold_full, done, busy, frame_end, load;
    logic [DATA_W-1:0] hold_data;

    // Load decision: byte ready, enabled, and the shifter idle or finishing.
    assign load = tx_en && hold_full && (!busy || frame_end);

    sc_tx_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wr_data   (wr_data),
        .load      (load),
        .frame_end (frame_end),
        .tx_en     (tx_en),
        .irq_en    (irq_en),
        .hold_data (hold_data),
        .hold_full (hold_full),
        .done      (done),
        .rd_data   (rd_data),
        .irq       (irq)
    );

    sc_tx_shifter #(.GUARD_BITS(GUARD_BITS)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (tx_en),
        .bit_tick  (bit_tick),
        .load      (load),
        .load_data (hold_data),
        .busy      (busy),
        .line      (line_out),
        .frame_end (frame_end)
    );

    // R6: back-to-back frames start on the same edge that ends the previous frame.
    a_r6_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && hold_full) |=> (busy && !line_out));
    // R7: interrupt only with the enable set.
    a_r7_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);
    // R9: no frame starts while disabled.
    a_r9_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> !load);
endmodule

// File: tb/sc_char_tx_tb.sv
module sc_char_tx_tb;
    localparam int G = 2;

    logic       clk = 0, rst_n = 0, bit_tick = 0, wr_en = 0;
    logic [1:0] addr = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] rd_data;
    logic       line_out, irq;
    int n_checks = 0, n_err = 0, cyc = 0;

    sc_char_tx #(.GUARD_BITS(G)) u_dut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
        .line_out(line_out), .irq(irq));

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_checks++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1; addr = a; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        addr = a; #1; d = rd_data;
    endtask

    task automatic tick();
        @(negedge clk); bit_tick = 1;
        @(negedge clk); bit_tick = 0;
    endtask

    // Runs data, parity and guard periods of a frame whose start bit is showing.
    task automatic run_frame(input logic [7:0] d);
        logic [7:0] s;
        for (int i = 0; i < 8; i++) begin
            tick(); chk("R2 data bit", {7'b0, line_out}, {7'b0, d[i]});
        end
        tick(); chk("R3 parity", {7'b0, line_out}, {7'b0, ^d});
        for (int g = 0; g < G; g++) begin
            tick(); chk("R4 guard high", {7'b0, line_out}, 8'h01);
            rd(2, s); chk("R4 no end in guard", {7'b0, s[1]}, 8'h00);
        end
    endtask

    task automatic test_reset();
        logic [7:0] v;
        chk("R1 line idle", {7'b0, line_out}, 8'h01);
        chk("R1 irq", {7'b0, irq}, 8'h00);
        rd(0, v); chk("R1 ctrl", v, 8'h00);
        rd(2, v); chk("R1 status", v, 8'h01);
    endtask

    task automatic test_single(input logic [7:0] d);
        logic [7:0] v;
        wr(0, 8'h01);
        wr(1, d);
        rd(2, v); chk("R5 write clears empty", v, 8'h00);
        rd(1, v); chk("R10 data readback", v, d);
        chk("R2 line high before load", {7'b0, line_out}, 8'h01);
        @(negedge clk);
        chk("R2 start bit", {7'b0, line_out}, 8'h00);
        rd(2, v); chk("R5 load sets empty", v, 8'h01);
        run_frame(d);
        tick();
        rd(2, v); chk("R6 end sets done", v, 8'h03);
        chk("R7 irq off without enable", {7'b0, irq}, 8'h00);
        wr(2, 8'h02);
        rd(2, v); chk("R8 clear done", v, 8'h01);
    endtask

    task automatic test_back_to_back();
        logic [7:0] v;
        wr(0, 8'h01);
        wr(1, 8'h3C);
        @(negedge clk);
        wr(1, 8'h81);
        rd(2, v); chk("R5 second byte pending", v, 8'h00);
        run_frame(8'h3C);
        tick();
        chk("R6 no gap start bit", {7'b0, line_out}, 8'h00);
        rd(2, v); chk("R6 boundary done and empty", v, 8'h03);
        chk("R7 gate closed", {7'b0, irq}, 8'h00);
        wr(2, 8'h00);
        rd(2, v); chk("R8 zero write keeps done", v, 8'h03);
        wr(2, 8'h02);
        rd(2, v); chk("R8 clear done", v, 8'h01);
        wr(0, 8'h03);
        chk("R7 enable with done 0", {7'b0, irq}, 8'h00);
        run_frame(8'h81);
        tick();
        chk("R7 irq on last frame", {7'b0, irq}, 8'h01);
        wr(0, 8'h01);
        chk("R7 enable off drops irq", {7'b0, irq}, 8'h00);
        rd(2, v); chk("R7 flag kept", v, 8'h03);
        wr(0, 8'h03);
        chk("R7 irq back", {7'b0, irq}, 8'h01);
        wr(2, 8'h02);
        chk("R7 irq after clear", {7'b0, irq}, 8'h00);
    endtask

    task automatic test_disable();
        logic [7:0] v;
        wr(0, 8'h01);
        wr(1, 8'hF0);
        @(negedge clk);
        tick(); tick(); tick(); tick(); tick();
        chk("R2 mid frame bit D4", {7'b0, line_out}, 8'h01);
        tick();
        chk("R2 mid frame bit D5", {7'b0, line_out}, 8'h01);
        wr(0, 8'h00);
        @(negedge clk);
        chk("R9 line forced high", {7'b0, line_out}, 8'h01);
        tick(); tick();
        chk("R9 stays high", {7'b0, line_out}, 8'h01);
        wr(1, 8'h5A);
        repeat (4) @(negedge clk);
        chk("R9 no start while off", {7'b0, line_out}, 8'h01);
        rd(2, v); chk("R9 byte kept", v, 8'h00);
        rd(1, v); chk("R10 held byte", v, 8'h5A);
        rd(0, v); chk("R10 ctrl readback", v, 8'h00);
        wr(0, 8'h01);
        @(negedge clk);
        chk("R9 resume start bit", {7'b0, line_out}, 8'h00);
        run_frame(8'h5A);
        tick();
        rd(2, v); chk("R6 end after resume", v, 8'h03);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        test_reset();
        test_single(8'hA5);
        test_single(8'h07);
        test_back_to_back();
        test_disable();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule